// File: doc/BRIEF.md
# Locking Request Arbiter for a Routing Node

This block decides which of the eight packet sources of a routing node may drive the shared packet bus next. While the arbiter is idle, any raised request triggers a sample. The whole set of pending requests is copied into a lock register at that moment. One clock later the copy is confirmed against the live requests, and a single winner is chosen from what remains. From then on the set is frozen. A requester that shows up after the sample waits for the next arbitration cycle, so each cycle makes exactly one decision.

The winner keeps a one-hot grant until the sink reports that the transfer is complete. Single-word packets finish after one done pulse. Two-word packets take two pulses: the header travels first, then a word-select output switches to the data word. When the cycle ends, the lock is cleared and the arbiter reopens. If the served requester withdraws its request during its own cycle, the arbiter aborts that cycle and reopens the same way. Winners are chosen round-robin, starting from the port after the last one served.

Top module: `pkt_lock_arbiter`

## Requirements
- R1: While reset is high and on the first clock after it, grant_o is all zeros and word_sel_o is 0.
- R2: When the arbiter is idle and a request is raised before clock edge k, that request is sampled at edge k. The grant appears at edge k+1, after the confirmation step, so grant_o stays zero for one cycle.
- R3: At most one bit of grant_o is ever high.
- R4: A request raised after the sample edge is not granted in the current arbitration cycle, even when it would have priority.
- R5: A sampled request that is withdrawn before the confirmation edge is not granted. If no sampled request survives, no grant is issued and the arbiter is idle again one clock later.
- R6: The winner is the first confirmed requester in ascending index order that comes after the last granted port, wrapping from port 7 to port 0. After reset the search starts at port 0.
- R7: A grant stays unchanged while done_i is low and the granted request stays high. For a single-word packet (len2_i bit = 0 at the grant edge), one clock with done_i high drops the grant at that edge.
- R8: For a two-word packet (len2_i bit = 1 at the grant edge), word_sel_o is 0 for the header beat. The first done_i clock sets word_sel_o to 1 and keeps the grant. The second done_i clock drops the grant and returns word_sel_o to 0.
- R9: If the granted port lowers its request while granted, the grant drops at the next edge and the lock reopens. The next arbitration cycle starts on the following edge.
- R10: After a cycle ends while other requests are pending, grant_o is zero for exactly two cycles before the next grant appears.
- R11: done_i has no effect while no grant is active. grant_o and word_sel_o stay zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 8 | Bus request per source port |
| len2_i | input | 8 | Per port: 1 = two-word packet, 0 = single word |
| done_i | input | 1 | Transfer-done pulse from the sink, one per bus beat |
| grant_o | output | 8 | One-hot bus grant |
| word_sel_o | output | 1 | Bus word select: 0 = header, 1 = data |

## Verification
The hardest case to reach from the ports is a request that arrives in the single cycle between the sample edge and the grant edge. There are two forms. In the first, a higher-priority port is raised exactly one clock after a lower-priority port has triggered the sample. In the second, the only sampled request is withdrawn before confirmation. The bench drives inputs on the falling edge, so it can place each change precisely in that confirmation cycle. It then checks that the late port waits for the next cycle and that the withdrawn one is never granted. The round-robin wrap and the two-clock gap between cycles are checked by holding a fixed request pattern across several complete cycles.

// File: rtl/lockarb_pkg.sv
package lockarb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONF = 2'd1,
    ST_XFER = 2'd2
  } arb_state_t;
endpackage

// File: rtl/lockarb_snap.sv
module lockarb_snap #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         confirm_i,
  input  logic         clear_i,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] snap_o
);
  always_ff @(posedge clk) begin
    if (rst || clear_i) snap_o <= '0;
    else if (load_i)    snap_o <= req_i;
    else if (confirm_i) snap_o <= snap_o & req_i;
  end

  // Once locked, the set changes only on load, confirm or clear
  p_lock_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !confirm_i && !clear_i) |=> $stable(snap_o));
endmodule

// File: rtl/lockarb_rr.sv
module lockarb_rr #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  mask_i,
  input  logic [IW-1:0] last_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int cand;
      cand = (int'(last_i) + k) % N;
      if (!any_o && mask_i[cand]) begin
        idx_o = IW'(cand);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lockarb_ctrl.sv
module lockarb_ctrl
  import lockarb_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req_i,
  input  logic [N-1:0]  len2_i,
  input  logic          done_i,
  input  logic [N-1:0]  snap_i,
  input  logic [IW-1:0] pick_idx_i,
  input  logic          pick_any_i,
  output logic          load_o,
  output logic          confirm_o,
  output logic          clear_o,
  output logic [IW-1:0] last_o,
  output logic [N-1:0]  grant_o,
  output logic          word_o
);
  arb_state_t state;
  logic       two_q;
  logic       served_live;

  assign served_live = |(grant_o & req_i);

  always_comb begin
    load_o    = 1'b0;
    confirm_o = 1'b0;
    clear_o   = 1'b0;
    case (state)
      ST_IDLE: load_o    = |req_i;
      ST_CONF: confirm_o = 1'b1;
      ST_XFER: clear_o   = !served_live || (done_i && (word_o || !two_q));
      default: clear_o   = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      grant_o <= '0;
      word_o  <= 1'b0;
      two_q   <= 1'b0;
      last_o  <= IW'(N - 1);
    end else begin
      case (state)
        ST_IDLE: if (|req_i) state <= ST_CONF;
        ST_CONF: begin
          if (pick_any_i) begin
            grant_o <= N'(1) << pick_idx_i;
            last_o  <= pick_idx_i;
            two_q   <= len2_i[pick_idx_i];
            word_o  <= 1'b0;
            state   <= ST_XFER;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_XFER: begin
          if (!served_live) begin
            grant_o <= '0;
            word_o  <= 1'b0;
            state   <= ST_IDLE;
          end else if (done_i) begin
            if (two_q && !word_o) begin
              word_o <= 1'b1;
            end else begin
              grant_o <= '0;
              word_o  <= 1'b0;
              state   <= ST_IDLE;
            end
          end
        end
        default: begin
          grant_o <= '0;
          word_o  <= 1'b0;
          state   <= ST_IDLE;
        end
      endcase
    end
  end

  p_grant_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o));

  p_grant_locked_r4: assert property (@(posedge clk) disable iff (rst)
    (|grant_o) |-> ((grant_o & snap_i) == grant_o));

  p_grant_hold_r7: assert property (@(posedge clk) disable iff (rst)
    ((|grant_o) && !done_i && served_live) |=> $stable(grant_o));

  p_abort_drop_r9: assert property (@(posedge clk) disable iff (rst)
    ((|grant_o) && !served_live) |=> (grant_o == '0));

  p_word_step_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(word_o) |-> $past(done_i));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    ((grant_o == '0) && !pick_any_i) |=> (grant_o == '0));
endmodule

// File: rtl/pkt_lock_arbiter.sv
module pkt_lock_arbiter #(
  parameter int NPORT = 8,
  localparam int IW   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPORT-1:0] req_i,
  input  logic [NPORT-1:0] len2_i,
  input  logic             done_i,
  output logic [NPORT-1:0] grant_o,
  output logic             word_sel_o
);
  logic             load, confirm, clear;
  logic [NPORT-1:0] snap;
  logic [NPORT-1:0] confirmed;
  logic [IW-1:0]    last_idx, pick_idx;
  logic             pick_any;

  // Confirmation step: only sampled requests still held survive
  assign confirmed = snap & req_i;

  lockarb_snap #(.N(NPORT)) u_snap (
    .clk       (clk),
    .rst       (rst),
    .load_i    (load),
    .confirm_i (confirm),
    .clear_i   (clear),
    .req_i     (req_i),
    .snap_o    (snap)
  );

  lockarb_rr #(.N(NPORT), .IW(IW)) u_rr (
    .mask_i (confirmed),
    .last_i (last_idx),
    .idx_o  (pick_idx),
    .any_o  (pick_any)
  );

  lockarb_ctrl #(.N(NPORT), .IW(IW)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .req_i      (req_i),
    .len2_i     (len2_i),
    .done_i     (done_i),
    .snap_i     (snap),
    .pick_idx_i (pick_idx),
    .pick_any_i (pick_any),
    .load_o     (load),
    .confirm_o  (confirm),
    .clear_o    (clear),
    .last_o     (last_idx),
    .grant_o    (grant_o),
    .word_o     (word_sel_o)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (grant_o == '0 && !word_sel_o));
endmodule

// File: tb/tb_pkt_lock_arbiter.sv
module tb_pkt_lock_arbiter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] req = '0;
  logic [7:0] len2 = '0;
  logic       done = 1'b0;
  logic [7:0] grant;
  logic       wsel;
  int         n_chk = 0;
  int         n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_lock_arbiter dut (
    .clk(clk), .rst(rst), .req_i(req), .len2_i(len2), .done_i(done),
    .grant_o(grant), .word_sel_o(wsel)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; req = '0; len2 = '0; done = 1'b0;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic pulse_done();
    done = 1'b1; tick(); done = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; req = 8'hFF; done = 1'b1;
    tick();
    chk(grant, 8'h00, "R1 grant in reset");
    chk(wsel, 1'b0, "R1 wsel in reset");
    rst = 1'b0; req = '0; done = 1'b0;
    tick();
    chk(grant, 8'h00, "R1 grant after reset");
  endtask

  task automatic t_basic();
    do_reset();
    req = 8'h08;
    tick();
    chk(grant, 8'h00, "R2 no grant at sample edge");
    tick();
    chk(grant, 8'h08, "R2 grant after confirm");
    tick(); tick();
    chk(grant, 8'h08, "R7 grant held");
    pulse_done();
    chk(grant, 8'h00, "R7 single-word release");
    req = '0;
    tick(); tick();
  endtask

  task automatic t_two_word();
    do_reset();
    len2 = 8'h40; req = 8'h40;
    tick(); tick();
    chk(grant, 8'h40, "R8 grant two-word");
    chk(wsel, 1'b0, "R8 header beat");
    pulse_done();
    chk(wsel, 1'b1, "R8 data beat");
    chk(grant, 8'h40, "R8 grant kept after first beat");
    tick();
    chk(wsel, 1'b1, "R8 data beat held");
    pulse_done();
    chk(grant, 8'h00, "R8 release after second beat");
    chk(wsel, 1'b0, "R8 wsel back to header");
    req = '0; len2 = '0;
    tick(); tick();
  endtask

  task automatic t_round_robin();
    do_reset();
    req = 8'b1000_0101;
    tick(); tick();
    chk(grant, 8'h01, "R6 first winner port0");
    chk($countones(grant), 1, "R3 one-hot");
    pulse_done();
    chk(grant, 8'h00, "R10 gap cycle 1");
    tick();
    chk(grant, 8'h00, "R10 gap cycle 2");
    tick();
    chk(grant, 8'h04, "R6 next winner port2");
    pulse_done(); tick(); tick();
    chk(grant, 8'h80, "R6 next winner port7");
    pulse_done(); tick(); tick();
    chk(grant, 8'h01, "R6 wrap to port0");
    req = '0;
    tick(); tick();
  endtask

  task automatic t_late();
    do_reset();
    req = 8'h20;
    tick();
    req = 8'h21;
    tick();
    chk(grant, 8'h20, "R4 late request not granted");
    pulse_done(); tick(); tick();
    chk(grant, 8'h01, "R4 late request served next cycle");
    req = '0;
    tick(); tick();
  endtask

  task automatic t_confirm();
    do_reset();
    req = 8'h10;
    tick();
    req = 8'h00;
    tick();
    chk(grant, 8'h00, "R5 withdrawn request not granted");
    tick();
    chk(grant, 8'h00, "R5 still no grant");
    req = 8'h02;
    tick(); tick();
    chk(grant, 8'h02, "R5 lock reopened");
    req = '0;
    tick(); tick();
  endtask

  task automatic t_abort();
    do_reset();
    req = 8'h0A;
    tick(); tick();
    chk(grant, 8'h02, "R9 grant port1");
    req = 8'h08;
    tick();
    chk(grant, 8'h00, "R9 abort drops grant");
    tick(); tick();
    chk(grant, 8'h08, "R9 next cycle after abort");
    req = '0;
    tick(); tick();
  endtask

  task automatic t_idle_done();
    do_reset();
    done = 1'b1;
    tick(); tick(); tick();
    chk(grant, 8'h00, "R11 done while idle grant");
    chk(wsel, 1'b0, "R11 done while idle wsel");
    done = 1'b0;
    req = 8'h04;
    tick(); tick();
    chk(grant, 8'h04, "R11 normal cycle after idle done");
    req = '0;
    tick(); tick();
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_two_word();
    t_round_robin();
    t_late();
    t_confirm();
    t_abort();
    t_idle_done();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule